// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block turns the 6-bit major opcode of a 32-bit instruction into the steering signals of a single-cycle datapath. The supported classes are register-format arithmetic, word load, word store, branch-if-equal and unconditional jump. It also produces the coarse ALU class code, which a separate ALU control stage refines using the function field. The block is purely combinational and sits between the instruction memory output and the datapath multiplexers, the register file and the data memory.

The decoder also resolves branches. It combines its own branch flag with the ALU zero output to drive the next-PC branch select. Any signal that does not matter for an instruction is driven to 0. An opcode outside the five supported values gives all-zero controls and raises an illegal-opcode flag, so an unknown instruction can never write state or redirect the PC. All pins are plain control signals. There is no data stream and no handshake.

Top module: `main_ctrl_decoder`

## Requirements
- R1: Opcode 000000 (register format) gives dst_sel_rd=1, rf_wr_en=1 and alu_cls=10, with all other controls 0.
- R2: Opcode 100011 (word load) gives alu_b_imm=1, wb_from_mem=1, rf_wr_en=1, mem_rd_en=1 and alu_cls=00, with all other controls 0.
- R3: Opcode 101011 (word store) gives alu_b_imm=1, mem_wr_en=1 and alu_cls=00, with all other controls 0.
- R4: Opcode 000100 (branch-if-equal) gives is_branch=1 and alu_cls=01, with all other controls 0.
- R5: Opcode 000010 (jump) gives is_jump=1 and alu_cls=00, with all other controls 0.
- R6: pc_br_take is 1 exactly when is_branch is 1 and alu_zero_i is 1. For every other opcode alu_zero_i has no effect on any output.
- R7: Every opcode other than the five above gives opcode_bad=1 and all other outputs 0. The five supported opcodes give opcode_bad=0.
- R8: mem_rd_en and mem_wr_en are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Major opcode, instruction bits 31..26 |
| alu_zero_i | input | 1 | ALU result-is-zero flag |
| dst_sel_rd | output | 1 | Write register comes from the rd field (else rt) |
| alu_b_imm | output | 1 | ALU second operand is the sign-extended immediate |
| wb_from_mem | output | 1 | Write-back data comes from data memory (else ALU) |
| rf_wr_en | output | 1 | Register file write enable |
| mem_rd_en | output | 1 | Data memory read enable |
| mem_wr_en | output | 1 | Data memory write enable |
| is_branch | output | 1 | Instruction is a conditional branch |
| is_jump | output | 1 | Instruction is an unconditional jump |
| alu_cls | output | 2 | ALU class: 00 add, 01 subtract, 10 use function field |
| pc_br_take | output | 1 | Select the branch target as the next PC |
| opcode_bad | output | 1 | Opcode is not one of the supported five |

## Verification
The decoder holds no state, so a wrong class match or a wrong table row shows at the ports during the same cycle the opcode is applied. The bench checks it before the next clock edge. A fault in class matching shows up either as a supported opcode flagged illegal or as a stray write enable, and the full 64-opcode sweep exposes it. A fault in branch resolution appears only when alu_zero_i toggles, so each opcode is checked with both zero values.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  localparam int OPC_W   = 6;
  localparam int CLS_W   = 2;
  localparam int N_KINDS = 5;

  localparam logic [OPC_W-1:0] OPC_RFMT  = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;

  localparam logic [CLS_W-1:0] CLS_ADD  = 2'b00;
  localparam logic [CLS_W-1:0] CLS_SUB  = 2'b01;
  localparam logic [CLS_W-1:0] CLS_FUNC = 2'b10;

  typedef struct packed {
    logic             dst_rd;
    logic             b_imm;
    logic             wb_mem;
    logic             rf_we;
    logic             m_re;
    logic             m_we;
    logic             br;
    logic             jmp;
    logic [CLS_W-1:0] cls;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic logic [OPC_W-1:0] kind_opcode(input int k);
    case (k)
      0:       return OPC_RFMT;
      1:       return OPC_LOAD;
      2:       return OPC_STORE;
      3:       return OPC_BEQ;
      default: return OPC_JUMP;
    endcase
  endfunction

  function automatic ctrl_t kind_row(input int k);
    ctrl_t r;
    r = '0;
    case (k)
      0: begin r.dst_rd = 1'b1; r.rf_we = 1'b1; r.cls = CLS_FUNC; end
      1: begin r.b_imm = 1'b1; r.wb_mem = 1'b1; r.rf_we = 1'b1; r.m_re = 1'b1; r.cls = CLS_ADD; end
      2: begin r.b_imm = 1'b1; r.m_we = 1'b1; r.cls = CLS_ADD; end
      3: begin r.br = 1'b1; r.cls = CLS_SUB; end
      default: begin r.jmp = 1'b1; r.cls = CLS_ADD; end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mcd_kind_match.sv
module mcd_kind_match
  import mcd_pkg::*;
(
  input  logic [OPC_W-1:0]   opcode,
  output logic [N_KINDS-1:0] kind_hit,
  output logic               no_kind
);
  for (genvar k = 0; k < N_KINDS; k++) begin : g_cmp
    assign kind_hit[k] = (opcode == kind_opcode(k));
  end

  assign no_kind = ~|kind_hit;

  always_comb begin
    if (!$isunknown(opcode)) begin
      p_single_kind_r7: assert ($onehot0(kind_hit))
        else $error("opcode matched more than one kind");
    end
  end
endmodule

// File: rtl/mcd_row_select.sv
module mcd_row_select
  import mcd_pkg::*;
(
  input  logic [N_KINDS-1:0] kind_hit,
  output ctrl_t              ctrl
);
  logic [CTRL_W-1:0] masked [N_KINDS];

  for (genvar k = 0; k < N_KINDS; k++) begin : g_row
    assign masked[k] = kind_hit[k] ? CTRL_W'(kind_row(k)) : '0;
  end

  always_comb begin
    logic [CTRL_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < N_KINDS; k++) acc = acc | masked[k];
    ctrl = ctrl_t'(acc);
  end

  always_comb begin
    if (!$isunknown(kind_hit)) begin
      p_no_dual_mem_r8: assert (!(ctrl.m_re && ctrl.m_we))
        else $error("memory read and write both enabled");
    end
  end
endmodule

// File: rtl/mcd_branch_resolve.sv
module mcd_branch_resolve (
  input  logic br,
  input  logic zero,
  output logic take
);
  assign take = br & zero;
endmodule

// File: rtl/main_ctrl_decoder.sv
module main_ctrl_decoder
  import mcd_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic       alu_zero_i,
  output logic       dst_sel_rd,
  output logic       alu_b_imm,
  output logic       wb_from_mem,
  output logic       rf_wr_en,
  output logic       mem_rd_en,
  output logic       mem_wr_en,
  output logic       is_branch,
  output logic       is_jump,
  output logic [1:0] alu_cls,
  output logic       pc_br_take,
  output logic       opcode_bad
);
  logic [N_KINDS-1:0] kind_hit;
  logic               no_kind;
  ctrl_t              ctrl;

  mcd_kind_match u_match (
    .opcode   (opcode_i),
    .kind_hit (kind_hit),
    .no_kind  (no_kind)
  );

  mcd_row_select u_rows (
    .kind_hit (kind_hit),
    .ctrl     (ctrl)
  );

  mcd_branch_resolve u_br (
    .br   (ctrl.br),
    .zero (alu_zero_i),
    .take (pc_br_take)
  );

  assign dst_sel_rd  = ctrl.dst_rd;
  assign alu_b_imm   = ctrl.b_imm;
  assign wb_from_mem = ctrl.wb_mem;
  assign rf_wr_en    = ctrl.rf_we;
  assign mem_rd_en   = ctrl.m_re;
  assign mem_wr_en   = ctrl.m_we;
  assign is_branch   = ctrl.br;
  assign is_jump     = ctrl.jmp;
  assign alu_cls     = ctrl.cls;
  assign opcode_bad  = no_kind;

  always_comb begin
    if (!$isunknown({opcode_i, alu_zero_i})) begin
      p_bad_is_quiet_r7: assert (!opcode_bad || !(rf_wr_en || mem_wr_en || mem_rd_en || pc_br_take || is_jump))
        else $error("illegal opcode produced an active control");
      p_take_only_beq_r6: assert (!pc_br_take || (opcode_i == OPC_BEQ && alu_zero_i))
        else $error("branch taken without equal-branch and zero");
      p_jump_no_write_r5: assert (!is_jump || (!rf_wr_en && !mem_wr_en && !mem_rd_en))
        else $error("jump enabled a write or read");
      p_store_no_rf_r3: assert (!(opcode_i == OPC_STORE) || !rf_wr_en)
        else $error("store wrote the register file");
    end
  end
endmodule

// File: tb/main_ctrl_decoder_test.sv
module main_ctrl_decoder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode_i = '0;
  logic alu_zero_i = 1'b0;
  logic dst_sel_rd, alu_b_imm, wb_from_mem, rf_wr_en, mem_rd_en, mem_wr_en;
  logic is_branch, is_jump, pc_br_take, opcode_bad;
  logic [1:0] alu_cls;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  main_ctrl_decoder uut (
    .opcode_i(opcode_i), .alu_zero_i(alu_zero_i),
    .dst_sel_rd(dst_sel_rd), .alu_b_imm(alu_b_imm), .wb_from_mem(wb_from_mem),
    .rf_wr_en(rf_wr_en), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .is_branch(is_branch), .is_jump(is_jump), .alu_cls(alu_cls),
    .pc_br_take(pc_br_take), .opcode_bad(opcode_bad)
  );

  // packed view: {dst,imm,wbm,rfwe,mre,mwe,br,jmp,cls[1:0],take,bad}
  function automatic logic [11:0] observed();
    return {dst_sel_rd, alu_b_imm, wb_from_mem, rf_wr_en, mem_rd_en, mem_wr_en,
            is_branch, is_jump, alu_cls, pc_br_take, opcode_bad};
  endfunction

  function automatic logic [11:0] expect_for(input logic [5:0] op, input logic z);
    case (op)
      6'b000000: return 12'b1001_0000_1000;
      6'b100011: return 12'b0111_1000_0000;
      6'b101011: return 12'b0100_0100_0000;
      6'b000100: return {8'b0000_0010, 2'b01, z, 1'b0};
      6'b000010: return 12'b0000_0001_0000;
      default:   return 12'b0000_0000_0001;
    endcase
  endfunction

  task automatic apply_and_check(input string tag, input logic [5:0] op, input logic z);
    logic [11:0] exp;
    @(negedge clk);
    opcode_i = op;
    alu_zero_i = z;
    #2;
    exp = expect_for(op, z);
    n_chk++;
    if (observed() !== exp) begin
      n_bad++;
      $display("FAIL %s op=%b zero=%b actual=%b expected=%b", tag, op, z, observed(), exp);
    end
  endtask

  task automatic t_reset_state;
    // held opcode 000000 during reset: register-format vector, R1
    @(negedge clk);
    n_chk++;
    if (observed() !== 12'b1001_0000_1000) begin
      n_bad++;
      $display("FAIL R1 reset actual=%b expected=%b", observed(), 12'b1001_0000_1000);
    end
  endtask

  task automatic t_rfmt;  apply_and_check("R1", 6'b000000, 1'b0); apply_and_check("R1", 6'b000000, 1'b1); endtask
  task automatic t_load;  apply_and_check("R2", 6'b100011, 1'b0); apply_and_check("R2", 6'b100011, 1'b1); endtask
  task automatic t_store; apply_and_check("R3", 6'b101011, 1'b0); apply_and_check("R3", 6'b101011, 1'b1); endtask
  task automatic t_beq;   apply_and_check("R4", 6'b000100, 1'b0); endtask
  task automatic t_jump;  apply_and_check("R5", 6'b000010, 1'b0); apply_and_check("R5", 6'b000010, 1'b1); endtask

  task automatic t_branch_take;
    apply_and_check("R6", 6'b000100, 1'b1);
    apply_and_check("R6", 6'b000100, 1'b0);
    apply_and_check("R6", 6'b000100, 1'b1);
  endtask

  task automatic t_sweep_all;
    for (int o = 0; o < 64; o++) begin
      for (int z = 0; z < 2; z++) begin
        apply_and_check("R7", 6'(o), 1'(z));
      end
    end
  endtask

  task automatic t_mem_exclusive;
    for (int o = 0; o < 64; o++) begin
      @(negedge clk);
      opcode_i = 6'(o);
      #2;
      n_chk++;
      if (mem_rd_en && mem_wr_en) begin
        n_bad++;
        $display("FAIL R8 op=%b actual=11 expected=not both", 6'(o));
      end
    end
  endtask

  initial begin
    #20000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_rfmt();
    t_load();
    t_store();
    t_beq();
    t_jump();
    t_branch_take();
    t_sweep_all();
    t_mem_exclusive();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule